// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This combinational block takes two unsigned operands of the same width `W` and produces `N` partial-product rows, each `W` bits wide. A downstream adder tree adds these rows. Each row is already shifted to its bit position and is already truncated to `W` bits. When `N` is at least the number of rows the chosen scheme needs, the rows add up, modulo 2^W, to `opa * opb` modulo 2^W. The final carry-propagate addition is not part of this block, and neither is the double-width product.

A parameter-driven choice selects one of two schemes. For wide operands, or when a force parameter is set, the multiplier is recoded into radix-4 Booth digits. This roughly halves the number of rows. Each negative digit is handled in two parts: its row is inverted bitwise, and a single correction bit is injected into the low end of the next row. For narrow operands without the force parameter, a plain AND array produces one row per multiplier bit.

The block has no clock, no state and no reset. Its outputs follow its inputs within the same cycle.

Top module: `booth_pp_gen`

## Requirements
- R1: Booth digit `j` is read from the multiplier bits at positions 2j+1, 2j and 2j-1. Position -1 and any position at or above `W` read as 0. The invert flag is the bit at 2j+1. The single-select flag is the XOR of the bits at 2j and 2j-1. The double-select flag is set when the top bit differs from both lower bits and the two lower bits are equal. The single-select and double-select flags are never set together.
- R2: The uncorrected Booth row is formed from two terms ORed together: `opa` gated by the single-select flag, and `opa` shifted left by one gated by the double-select flag. The result is then XORed with `W` copies of the invert flag. Row 0 is this value, unshifted and with no correction bit.
- R3: Booth row `j ≥ 1` is built in three steps. First, concatenate the uncorrected row, a zero bit, and the invert flag of digit `j-1`, with that invert flag as bit 0. Second, keep the low `W` bits. Third, shift left by `2j-2`. As a result, bit `2j-2` holds the previous invert flag and bit `2j-1` is zero, whenever those positions are below `W`.
- R4: When `N` reaches the row count of the active scheme, the rows sum modulo 2^W to `opa*opb` modulo 2^W. The Booth row count is `W/2+1`, rounded down; the AND-array row count is `W`.
- R5: For even `W`, the last Booth row (index `W/2`) has a single possible set bit, at position `W-2`. That bit equals the invert flag of the preceding digit, which is multiplier bit `W-1`.
- R6: Output rows whose index is at or beyond the Booth row count are all zero.
- R7: Booth mode is active when `W > BOOTH_MIN_W` (default 16) or when `FORCE_BOOTH` is set. Otherwise the AND array is used.
- R8: In AND-array mode, row `k` is `opa` gated by multiplier bit `k` and shifted left by `k`.
- R9: When `N` is below the Booth row count, only rows `0..N-1` are produced, and each is identical to the row at that index with a larger `N`.
- R10: Row `k` occupies bits `[k*W +: W]` of `pp_rows`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | Multiplicand, unsigned |
| opb | input | W | Multiplier, unsigned; recoded in Booth mode |
| pp_rows | output | N*W | Packed partial-product rows, row k at [k*W +: W] |

## Verification
On every evaluation, the embedded assertions check four properties:
- the select flags are mutually exclusive;
- a row with neither select flag set reduces to copies of the invert flag;
- the correction bit and the zero guard bit sit at their fixed positions in each later Booth row;
- the rows sum to the truncated product whenever the row count is sufficient.

The bench scenarios cover what the assertions cannot see: the choice of scheme at the width threshold, zero padding of unused rows, the even-width trailing row, and the truncated-row-count case. These are exercised exhaustively at widths 4 to 6 and with random operands at widths 24 and 25.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bdigit_t;

    function automatic int booth_row_count(input int width);
        return width / 2 + 1;
    endfunction

    function automatic bit booth_selected(input int width, input bit force_b, input int min_w);
        return (width > min_w) || force_b;
    endfunction

    function automatic int min_int(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
    import booth_pp_pkg::*;
(
    input  logic [2:0] triple,   // {hi, mid, lo}
    output bdigit_t    dig
);
    always_comb begin
        dig.neg = triple[2];
        dig.one = triple[1] ^ triple[0];
        dig.two = (~triple[2] & triple[1] & triple[0]) | (triple[2] & ~triple[1] & ~triple[0]);
    end

    always_comb begin
        AST_SEL_EXCLUSIVE: assert (!(dig.one && dig.two)) else $error("select flags overlap"); // R1
    end
endmodule

// File: rtl/booth_row_build.sv
module booth_row_build
    import booth_pp_pkg::*;
#(
    parameter int W     = 8,
    parameter int SHIFT = 0,
    parameter bit FIRST = 1'b1
) (
    input  logic [W-1:0] mcand,
    input  bdigit_t      dig,
    input  logic         neg_prev,
    output logic [W-1:0] row
);
    logic [W-1:0] twice;
    logic [W-1:0] base;
    logic [W-1:0] pre;

    assign twice = {mcand[W-2:0], 1'b0};
    assign base  = (({W{dig.two}} & twice) | ({W{dig.one}} & mcand)) ^ {W{dig.neg}};

    generate
        if (FIRST) begin : g_first
            assign row = base;
            always_comb begin
                AST_FIRST_NO_CORR: assert (neg_prev == 1'b0) else $error("row 0 fed a correction"); // R2
            end
        end else begin : g_later
            if (W > 2) begin : g_wide
                assign pre = {base[W-3:0], 1'b0, neg_prev};
            end else begin : g_narrow
                logic unused_base;
                assign unused_base = ^base;
                assign pre = {1'b0, neg_prev};
            end
            assign row = pre << SHIFT;
            if (SHIFT + 1 < W) begin : g_corr_chk
                always_comb begin
                    AST_CORR_BIT_PLACED: assert (row[SHIFT] == neg_prev && row[SHIFT+1] == 1'b0)
                        else $error("correction bit misplaced"); // R3
                end
            end
        end
    endgenerate

    always_comb begin
        AST_IDLE_ROW_IS_SIGN: assert (dig.one || dig.two || base == {W{dig.neg}})
            else $error("unselected row not sign fill"); // R2
    end
endmodule

// File: rtl/and_row_build.sv
module and_row_build #(
    parameter int W     = 8,
    parameter int SHIFT = 0
) (
    input  logic [W-1:0] mcand,
    input  logic         sel,
    output logic [W-1:0] row
);
    assign row = (mcand & {W{sel}}) << SHIFT;

    always_comb begin
        AST_AND_ROW_GATED: assert (sel || row == '0) else $error("row set without multiplier bit"); // R8
    end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_pp_pkg::*;
#(
    parameter int W           = 8,
    parameter int N           = 8,
    parameter bit FORCE_BOOTH = 1'b0,
    parameter int BOOTH_MIN_W = 16
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [N*W-1:0] pp_rows
);
    localparam bit USE_BOOTH = booth_selected(W, FORCE_BOOTH, BOOTH_MIN_W);
    localparam int NDIG      = booth_row_count(W);
    localparam int NGEN      = USE_BOOTH ? min_int(N, NDIG) : N;
    localparam bit FULL_SUM  = USE_BOOTH ? (N >= NDIG) : (N >= W);

    logic [W-1:0] row_w [N];

    generate
        if (USE_BOOTH) begin : g_booth
            bdigit_t dig_w [NGEN];
            for (genvar j = 0; j < NGEN; j++) begin : g_dig
                logic [2:0] trip;
                if (j == 0) begin : g_lo0
                    assign trip[0] = 1'b0;
                end else begin : g_lo
                    assign trip[0] = opb[2*j-1];
                end
                if (2*j < W) begin : g_mid
                    assign trip[1] = opb[2*j];
                end else begin : g_mid0
                    assign trip[1] = 1'b0;
                end
                if (2*j + 1 < W) begin : g_hi
                    assign trip[2] = opb[2*j+1];
                end else begin : g_hi0
                    assign trip[2] = 1'b0;
                end
                booth_digit_enc u_enc (.triple(trip), .dig(dig_w[j]));
                if (j == 0) begin : g_row0
                    booth_row_build #(.W(W), .SHIFT(0), .FIRST(1'b1)) u_row (
                        .mcand(opa), .dig(dig_w[j]), .neg_prev(1'b0), .row(row_w[j]));
                end else begin : g_rowj
                    booth_row_build #(.W(W), .SHIFT(2*j-2), .FIRST(1'b0)) u_row (
                        .mcand(opa), .dig(dig_w[j]), .neg_prev(dig_w[j-1].neg), .row(row_w[j]));
                end
            end
            for (genvar k = NGEN; k < N; k++) begin : g_pad
                assign row_w[k] = '0;
            end
        end else begin : g_and
            for (genvar k = 0; k < N; k++) begin : g_row
                and_row_build #(.W(W), .SHIFT(k)) u_row (
                    .mcand(opa), .sel(opb[k]), .row(row_w[k]));
            end
        end

        for (genvar k = 0; k < N; k++) begin : g_pack
            assign pp_rows[k*W +: W] = row_w[k];
        end
    endgenerate

    logic [W-1:0] row_sum;
    logic [W-1:0] trunc_prod;

    always_comb begin
        row_sum = '0;
        for (int k = 0; k < N; k++) begin
            row_sum = row_sum + pp_rows[k*W +: W];
        end
        trunc_prod = opa * opb;
        if (FULL_SUM) begin
            AST_SUM_EQ_PRODUCT: assert (row_sum == trunc_prod) else $error("rows do not sum to product"); // R4
        end
    end
endmodule

// File: tb/booth_pp_gen_test.sv
module booth_pp_gen_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [4:0]  a5, b5;
    logic [5:0]  a6, b6, at, bt;
    logic [3:0]  a4, b4;
    logic [15:0] a16, b16;
    logic [16:0] a17, b17;
    logic [23:0] a24, b24;
    logic [24:0] a25, b25;

    logic [24:0]  p5a, p5b;
    logic [35:0]  p6a, p6b;
    logic [15:0]  p4b;
    logic [11:0]  pt;
    logic [255:0] p16;
    logic [288:0] p17;
    logic [575:0] p24;
    logic [624:0] p25;

    booth_pp_gen #(.W(5),  .N(5),  .FORCE_BOOTH(1'b0)) uut_a5 (.opa(a5), .opb(b5), .pp_rows(p5a));
    booth_pp_gen #(.W(5),  .N(5),  .FORCE_BOOTH(1'b1)) uut_b5 (.opa(a5), .opb(b5), .pp_rows(p5b));
    booth_pp_gen #(.W(6),  .N(6),  .FORCE_BOOTH(1'b0)) uut_a6 (.opa(a6), .opb(b6), .pp_rows(p6a));
    booth_pp_gen #(.W(6),  .N(6),  .FORCE_BOOTH(1'b1)) uut_b6 (.opa(a6), .opb(b6), .pp_rows(p6b));
    booth_pp_gen #(.W(4),  .N(4),  .FORCE_BOOTH(1'b1)) uut_b4 (.opa(a4), .opb(b4), .pp_rows(p4b));
    booth_pp_gen #(.W(6),  .N(2),  .FORCE_BOOTH(1'b1)) uut_t6 (.opa(at), .opb(bt), .pp_rows(pt));
    booth_pp_gen #(.W(16), .N(16)) uut_16 (.opa(a16), .opb(b16), .pp_rows(p16));
    booth_pp_gen #(.W(17), .N(17)) uut_17 (.opa(a17), .opb(b17), .pp_rows(p17));
    booth_pp_gen #(.W(24), .N(24)) uut    (.opa(a24), .opb(b24), .pp_rows(p24));
    booth_pp_gen #(.W(25), .N(25)) uut_25 (.opa(a25), .opb(b25), .pp_rows(p25));

    function automatic longint mask_of(input int w);
        return (longint'(1) << w) - 1;
    endfunction

    function automatic longint bit_at(input longint v, input int pos, input int w);
        if (pos < 0 || pos >= w) return 0;
        return (v >> pos) & 1;
    endfunction

    // Expected Booth row from the digit value: -2*hi + mid + lo
    function automatic longint exp_booth(input int w, input int j, input longint a, input longint b);
        longint hi, mid, lo, d, mag, r, pn;
        hi  = bit_at(b, 2*j+1, w);
        mid = bit_at(b, 2*j, w);
        lo  = bit_at(b, 2*j-1, w);
        d   = -2*hi + mid + lo;
        mag = (d < 0 ? -d : d) * a;
        r   = (hi != 0) ? ~mag : mag;
        r   = r & mask_of(w);
        if (j == 0) return r;
        pn = bit_at(b, 2*j-1, w);
        return (((r << 2) | pn) << (2*j-2)) & mask_of(w);
    endfunction

    function automatic longint exp_and(input int w, input int k, input longint a, input longint b);
        return (((b >> k) & 1) != 0) ? ((a << k) & mask_of(w)) : 0;
    endfunction

    function automatic longint row_of(input logic [1023:0] bus, input int w, input int k);
        return longint'(bus >> (k*w)) & mask_of(w);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Checks every row (R10 layout) and, for a full row count, the sum (R4)
    task automatic check_vec(input int w, input int n, input bit booth, input longint a,
                             input longint b, input logic [1023:0] bus);
        int ndig = w/2 + 1;
        longint sum = 0;
        for (int k = 0; k < n; k++) begin
            longint e;
            if (booth) e = (k < ndig) ? exp_booth(w, k, a, b) : 0;
            else       e = exp_and(w, k, a, b);
            check(booth ? "R1/R2/R3/R10 booth row" : "R8/R10 and row", row_of(bus, w, k), e);
            sum += row_of(bus, w, k);
        end
        if ((booth && n >= ndig) || (!booth && n >= w))
            check("R4 row sum", sum & mask_of(w), (a*b) & mask_of(w));
    endtask

    task automatic t_zero_operands;
        @(posedge clk);
        a24 = '0; b24 = '0; a5 = '0; b5 = '0;
        @(negedge clk);
        check("R2 zero operands uut", longint'(p24 != '0), 0);
        check("R2 zero operands uut_b5", longint'(p5b != '0), 0);
    endtask

    task automatic t_exhaustive_small;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(posedge clk);
                a5 = 5'(a); b5 = 5'(b);
                @(negedge clk);
                check_vec(5, 5, 1'b0, a, b, 1024'(p5a));
                check_vec(5, 5, 1'b1, a, b, 1024'(p5b));
            end
        end
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                @(posedge clk);
                a6 = 6'(a); b6 = 6'(b);
                @(negedge clk);
                check_vec(6, 6, 1'b0, a, b, 1024'(p6a));
                check_vec(6, 6, 1'b1, a, b, 1024'(p6b));
            end
        end
    endtask

    task automatic t_even_tail_and_pad;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(posedge clk);
                a4 = 4'(a); b4 = 4'(b);
                @(negedge clk);
                check("R5 W4 tail row", row_of(1024'(p4b), 4, 2), ((b >> 3) & 1) << 2);
                check("R6 W4 pad row", row_of(1024'(p4b), 4, 3), 0);
                check_vec(4, 4, 1'b1, a, b, 1024'(p4b));
            end
        end
        @(posedge clk);
        a6 = 6'h3f; b6 = 6'h2a;
        @(negedge clk);
        check("R5 W6 tail row", row_of(1024'(p6b), 6, 3), longint'(1) << 4);
        check("R6 W6 pad row 4", row_of(1024'(p6b), 6, 4), 0);
        check("R6 W6 pad row 5", row_of(1024'(p6b), 6, 5), 0);
    endtask

    task automatic t_truncated_count;
        for (int a = 0; a < 64; a += 5) begin
            for (int b = 0; b < 64; b++) begin
                @(posedge clk);
                at = 6'(a); bt = 6'(b);
                @(negedge clk);
                check("R9 truncated row 0", row_of(1024'(pt), 6, 0), exp_booth(6, 0, a, b));
                check("R9 truncated row 1", row_of(1024'(pt), 6, 1), exp_booth(6, 1, a, b));
            end
        end
    endtask

    task automatic t_mode_select;
        // multiplier 3: AND row 0 = opa; Booth digit 0 = -1 -> row 0 = ~opa
        @(posedge clk);
        a16 = 16'd1; b16 = 16'd3; a17 = 17'd1; b17 = 17'd3; a24 = 24'd1; b24 = 24'd3;
        @(negedge clk);
        check("R7 W16 uses AND", row_of(1024'(p16), 16, 0), 1);
        check("R7 W17 uses Booth", row_of(1024'(p17), 17, 0), mask_of(17) - 1);
        check("R7 W24 uses Booth", row_of(1024'(p24), 24, 0), mask_of(24) - 1);
        check_vec(16, 16, 1'b0, 1, 3, 1024'(p16));
        check_vec(17, 17, 1'b1, 1, 3, 1024'(p17));
    endtask

    task automatic t_random_wide;
        for (int i = 0; i < 1500; i++) begin
            longint ra, rb, sa, sb;
            ra = longint'($urandom) & mask_of(24);
            rb = longint'($urandom) & mask_of(24);
            sa = longint'($urandom) & mask_of(25);
            sb = longint'($urandom) & mask_of(25);
            if (i == 0) begin ra = mask_of(24); rb = mask_of(24); sa = mask_of(25); sb = mask_of(25); end
            @(posedge clk);
            a24 = 24'(ra); b24 = 24'(rb); a25 = 25'(sa); b25 = 25'(sb);
            @(negedge clk);
            check_vec(24, 24, 1'b1, ra, rb, 1024'(p24));
            check_vec(25, 25, 1'b1, sa, sb, 1024'(p25));
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        a5 = '0; b5 = '0; a6 = '0; b6 = '0; a4 = '0; b4 = '0; at = '0; bt = '0;
        a16 = '0; b16 = '0; a17 = '0; b17 = '0; a24 = '0; b24 = '0; a25 = '0; b25 = '0;
        t_zero_operands();
        t_exhaustive_small();
        t_even_tail_and_pad();
        t_truncated_count();
        t_mode_select();
        t_random_wide();
        finish_run();
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule